// File: doc/BRIEF.md
# Scatter-Gather Address Generator

This block produces the source and destination byte addresses that a DMA channel uses, beat by beat, inside a single block transfer. The two sides are separate. Each keeps its own running address and moves it by the transfer width on every beat the bus logic reports for that side. The address can go up, go down, or stay fixed.

Each side also has a boundary counter. On the source side this implements gather, and on the destination side it implements scatter. Software sets how many beats lie between boundaries. On the beat that reaches a boundary, the address moves by a separate programmed interval, upward or downward, on top of the normal per-beat step, and the counter starts again. A boundary count of zero turns the feature off for that side. A one-cycle start pulse loads the initial addresses and clears both counters. Bus signalling and the sequencing of blocks belong to other logic.

Top module: `sgAddrGen`

## Requirements
- R1: After reset, both addresses read zero. A cycle with `start` high loads `srcAddr` from `srcInit` and `dstAddr` from `dstInit`, visible one clock later, and clears both boundary counters. A `start` overrides any advance strobe in the same cycle.
- R2: In a cycle with neither `start` nor a side's advance strobe, that side's address keeps its value.
- R3: The per-beat step is set by `xferSize`: 0 gives 1 byte, 1 gives 2 bytes, and 2 or 3 give 4 bytes. The step applies to both sides.
- R4: Each side has a 2-bit mode: 0 adds the step on each advance, 1 subtracts it, and 2 or 3 leave the address unchanged by the step.
- R5: With `gatherCount` = N > 0, source beats are counted from start or from the last boundary. The N-th such beat is a boundary beat. On it, `gatherInterval` is also added to the source address (or subtracted when `gatherDown` = 1), and the count restarts.
- R6: With `scatterCount` = N > 0, the destination side follows the same rule using `scatterInterval` and `scatterDown`.
- R7: A count of zero means no boundary beats ever occur on that side. Only the plain step is applied.
- R8: An advance on one side changes neither the other side's address nor its boundary count.
- R9: Address arithmetic wraps modulo 2^ADDR_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Load initial addresses, clear boundary counters |
| srcInit | input | ADDR_W | Initial source address |
| dstInit | input | ADDR_W | Initial destination address |
| xferSize | input | 2 | Transfer width code (1, 2, 4 bytes) |
| srcMode | input | 2 | Source step direction |
| dstMode | input | 2 | Destination step direction |
| gatherCount | input | CNT_W | Source beats per gather boundary, 0 = off |
| gatherInterval | input | IVL_W | Source jump at boundary |
| gatherDown | input | 1 | Source jump subtracts |
| scatterCount | input | CNT_W | Destination beats per scatter boundary, 0 = off |
| scatterInterval | input | IVL_W | Destination jump at boundary |
| scatterDown | input | 1 | Destination jump subtracts |
| srcAdvance | input | 1 | Source beat completed |
| dstAdvance | input | 1 | Destination beat completed |
| srcAddr | output | ADDR_W | Current source address |
| dstAddr | output | ADDR_W | Current destination address |

## Verification
The bench builds the block with ADDR_W = 16, CNT_W = 4 and IVL_W = 8. With a 16-bit address, wraparound past 0xFFFF and below zero happens after only a few steps and jumps, so R9 is exercised both in directed tests and in random runs. Random boundary counts from 0 to 5 make boundary beats frequent. They include the disabled value and the case where every beat is a boundary. Advance strobes are drawn independently per side, which covers start colliding with an advance, and one side running while the other idles.

// File: rtl/sg_pkg.sv
package sg_pkg;

  typedef enum logic [1:0] {
    MODE_INC  = 2'd0,
    MODE_DEC  = 2'd1,
    MODE_HOLD = 2'd2
  } stepMode_t;

  typedef struct packed {
    logic load;
    logic step;
    logic jump;
  } sideStrobe_t;

  localparam int SIDE_SRC = 0;
  localparam int SIDE_DST = 1;
  localparam int NUM_SIDES = 2;

  function automatic logic [2:0] stepBytes(input logic [1:0] sizeCode);
    case (sizeCode)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/sgCtrl.sv
module sgCtrl
  import sg_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                start,
  input  logic [NUM_SIDES-1:0]                advance,
  input  logic [NUM_SIDES-1:0][CNT_W-1:0]     limit,
  output sideStrobe_t [NUM_SIDES-1:0]         strb
);

  for (genvar g = 0; g < NUM_SIDES; g++) begin : g_side
    logic [CNT_W-1:0] beatCnt;
    logic [CNT_W:0]   nextCnt;
    logic             hit;

    assign nextCnt = {1'b0, beatCnt} + 1'b1;
    // boundary when the beat count reaches the limit; >= tolerates a lowered limit
    assign hit = advance[g] && (limit[g] != '0) && (nextCnt >= {1'b0, limit[g]});

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        beatCnt <= '0;
      end else if (start) begin
        beatCnt <= '0;
      end else if (advance[g]) begin
        beatCnt <= hit ? '0 : nextCnt[CNT_W-1:0];
      end
    end

    assign strb[g] = '{load: start,
                       step: advance[g] && !start,
                       jump: hit && !start};
  end

endmodule

// File: rtl/sgPath.sv
module sgPath
  import sg_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IVL_W  = 16
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  sideStrobe_t [NUM_SIDES-1:0]         strb,
  input  logic [NUM_SIDES-1:0][ADDR_W-1:0]    initAddr,
  input  logic [NUM_SIDES-1:0][1:0]           mode,
  input  logic [1:0]                          xferSize,
  input  logic [NUM_SIDES-1:0][IVL_W-1:0]     ivl,
  input  logic [NUM_SIDES-1:0]                down,
  output logic [NUM_SIDES-1:0][ADDR_W-1:0]    addr
);

  logic [ADDR_W-1:0] stepExt;
  assign stepExt = ADDR_W'(stepBytes(xferSize));

  for (genvar g = 0; g < NUM_SIDES; g++) begin : g_side
    logic [ADDR_W-1:0] cur;
    logic [ADDR_W-1:0] stepAdd, stepSub, jumpAdd, jumpSub;
    logic [ADDR_W-1:0] ivlExt;

    assign ivlExt = ADDR_W'(ivl[g]);

    always_comb begin
      stepAdd = '0;
      stepSub = '0;
      jumpAdd = '0;
      jumpSub = '0;
      if (mode[g] == MODE_INC)      stepAdd = stepExt;
      else if (mode[g] == MODE_DEC) stepSub = stepExt;
      if (strb[g].jump) begin
        if (down[g]) jumpSub = ivlExt;
        else         jumpAdd = ivlExt;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cur <= '0;
      end else if (strb[g].load) begin
        cur <= initAddr[g];
      end else if (strb[g].step) begin
        cur <= cur + stepAdd - stepSub + jumpAdd - jumpSub;
      end
    end

    assign addr[g] = cur;
  end

endmodule

// File: rtl/sgAddrGen.sv
module sgAddrGen
  import sg_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 12,
  parameter int IVL_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] srcInit,
  input  logic [ADDR_W-1:0] dstInit,
  input  logic [1:0]        xferSize,
  input  logic [1:0]        srcMode,
  input  logic [1:0]        dstMode,
  input  logic [CNT_W-1:0]  gatherCount,
  input  logic [IVL_W-1:0]  gatherInterval,
  input  logic              gatherDown,
  input  logic [CNT_W-1:0]  scatterCount,
  input  logic [IVL_W-1:0]  scatterInterval,
  input  logic              scatterDown,
  input  logic              srcAdvance,
  input  logic              dstAdvance,
  output logic [ADDR_W-1:0] srcAddr,
  output logic [ADDR_W-1:0] dstAddr
);

  sideStrobe_t [NUM_SIDES-1:0]        strb;
  logic [NUM_SIDES-1:0]               advance;
  logic [NUM_SIDES-1:0][CNT_W-1:0]    limit;
  logic [NUM_SIDES-1:0][ADDR_W-1:0]   initAddr;
  logic [NUM_SIDES-1:0][ADDR_W-1:0]   addr;
  logic [NUM_SIDES-1:0][1:0]          mode;
  logic [NUM_SIDES-1:0][IVL_W-1:0]    ivl;
  logic [NUM_SIDES-1:0]               down;

  assign advance  = {dstAdvance, srcAdvance};
  assign limit    = {scatterCount, gatherCount};
  assign initAddr = {dstInit, srcInit};
  assign mode     = {dstMode, srcMode};
  assign ivl      = {scatterInterval, gatherInterval};
  assign down     = {scatterDown, gatherDown};

  sgCtrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .advance (advance),
    .limit   (limit),
    .strb    (strb)
  );

  sgPath #(.ADDR_W(ADDR_W), .IVL_W(IVL_W)) u_path (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb     (strb),
    .initAddr (initAddr),
    .mode     (mode),
    .xferSize (xferSize),
    .ivl      (ivl),
    .down     (down),
    .addr     (addr)
  );

  assign srcAddr = addr[SIDE_SRC];
  assign dstAddr = addr[SIDE_DST];

endmodule

// File: rtl/sgAddrGenChecker.sv
module sgAddrGenChecker #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [ADDR_W-1:0] srcInit,
  input logic [ADDR_W-1:0] dstInit,
  input logic [1:0]        xferSize,
  input logic [1:0]        srcMode,
  input logic [1:0]        dstMode,
  input logic [CNT_W-1:0]  gatherCount,
  input logic [CNT_W-1:0]  scatterCount,
  input logic              srcAdvance,
  input logic              dstAdvance,
  input logic [ADDR_W-1:0] srcAddr,
  input logic [ADDR_W-1:0] dstAddr
);

  p_start_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (srcAddr == $past(srcInit)) && (dstAddr == $past(dstInit)));

  p_src_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !srcAdvance) |=> $stable(srcAddr));

  p_dst_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !dstAdvance) |=> $stable(dstAddr));

  p_word_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && srcAdvance && srcMode == 2'd0 && gatherCount == '0 && xferSize[1])
      |=> srcAddr == $past(srcAddr) + ADDR_W'(4));

  p_dec_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && dstAdvance && dstMode == 2'd1 && scatterCount == '0 && xferSize == 2'd0)
      |=> dstAddr == $past(dstAddr) - ADDR_W'(1));

  p_hold_nojump_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && srcAdvance && srcMode[1] && gatherCount == '0) |=> $stable(srcAddr));

endmodule

bind sgAddrGen sgAddrGenChecker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start        (start),
  .srcInit      (srcInit),
  .dstInit      (dstInit),
  .xferSize     (xferSize),
  .srcMode      (srcMode),
  .dstMode      (dstMode),
  .gatherCount  (gatherCount),
  .scatterCount (scatterCount),
  .srcAdvance   (srcAdvance),
  .dstAdvance   (dstAdvance),
  .srcAddr      (srcAddr),
  .dstAddr      (dstAddr)
);

// File: tb/sgAddrGen_bench.sv
module sgAddrGen_bench;

  localparam int AW = 16;
  localparam int CW = 4;
  localparam int IW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] srcInit = '0, dstInit = '0;
  logic [1:0]    xferSize = '0, srcMode = '0, dstMode = '0;
  logic [CW-1:0] gatherCount = '0, scatterCount = '0;
  logic [IW-1:0] gatherInterval = '0, scatterInterval = '0;
  logic          gatherDown = 1'b0, scatterDown = 1'b0;
  logic          srcAdvance = 1'b0, dstAdvance = 1'b0;
  logic [AW-1:0] srcAddr, dstAddr;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit finished = 0;

  int mSrc = 0, mDst = 0, mSrcCnt = 0, mDstCnt = 0;

  always #2 clk = ~clk;

  sgAddrGen #(.ADDR_W(AW), .CNT_W(CW), .IVL_W(IW)) u_sgAddrGen (
    .clk(clk), .rst_n(rst_n), .start(start),
    .srcInit(srcInit), .dstInit(dstInit), .xferSize(xferSize),
    .srcMode(srcMode), .dstMode(dstMode),
    .gatherCount(gatherCount), .gatherInterval(gatherInterval), .gatherDown(gatherDown),
    .scatterCount(scatterCount), .scatterInterval(scatterInterval), .scatterDown(scatterDown),
    .srcAdvance(srcAdvance), .dstAdvance(dstAdvance),
    .srcAddr(srcAddr), .dstAddr(dstAddr)
  );

  function automatic int sizeOf(input logic [1:0] code);
    return (code == 2'd0) ? 1 : (code == 2'd1) ? 2 : 4;
  endfunction

  function automatic int nextAddr(input int a, input logic [1:0] md, input logic [1:0] code,
                                  input bit jump, input int iv, input bit dn);
    int r = a;
    if (md == 2'd0) r = r + sizeOf(code);
    else if (md == 2'd1) r = r - sizeOf(code);
    if (jump) r = dn ? r - iv : r + iv;
    return r & ((1 << AW) - 1);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // inputs already driven at a negedge; advance model, clock once, compare
  task automatic doCycle(input string srcTag, input string dstTag);
    bit hit;
    if (start) begin
      mSrc = int'(srcInit); mDst = int'(dstInit); mSrcCnt = 0; mDstCnt = 0;
    end else begin
      if (srcAdvance) begin
        hit = (gatherCount != 0) && (mSrcCnt + 1 >= int'(gatherCount));
        mSrc = nextAddr(mSrc, srcMode, xferSize, hit, int'(gatherInterval), gatherDown);
        mSrcCnt = hit ? 0 : mSrcCnt + 1;
      end
      if (dstAdvance) begin
        hit = (scatterCount != 0) && (mDstCnt + 1 >= int'(scatterCount));
        mDst = nextAddr(mDst, dstMode, xferSize, hit, int'(scatterInterval), scatterDown);
        mDstCnt = hit ? 0 : mDstCnt + 1;
      end
    end
    @(posedge clk);
    @(negedge clk);
    check(srcTag, int'(srcAddr), mSrc);
    check(dstTag, int'(dstAddr), mDst);
  endtask

  task automatic loadAll(input int s, input int d);
    start = 1; srcInit = AW'(s); dstInit = AW'(d);
    doCycle("R1 src load", "R1 dst load");
    start = 0;
  endtask

  initial begin : watchdog
    while (!finished) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  initial begin : stim
    void'($urandom(32'h5eed_c0de));
    @(negedge clk);
    @(negedge clk);
    check("R1 reset src", int'(srcAddr), 0);
    check("R1 reset dst", int'(dstAddr), 0);
    rst_n = 1;

    // R1: start wins over simultaneous advances
    srcAdvance = 1; dstAdvance = 1; xferSize = 2;
    loadAll(16'h1000, 16'h2000);
    srcAdvance = 0; dstAdvance = 0;

    // R2: idle holds
    for (int i = 0; i < 3; i++) doCycle("R2 src idle", "R2 dst idle");

    // R3: each size incrementing
    for (int sz = 0; sz < 4; sz++) begin
      xferSize = 2'(sz); srcAdvance = 1; dstAdvance = 1;
      doCycle("R3 src size", "R3 dst size");
    end

    // R4: decrement and hold modes
    srcMode = 1; dstMode = 2; xferSize = 1;
    for (int i = 0; i < 2; i++) doCycle("R4 src dec", "R4 dst hold");
    srcMode = 3; dstMode = 1;
    doCycle("R4 src hold3", "R4 dst dec");

    // R5/R6: boundaries, gather up by 0x10 every 3, scatter down by 0x20 every 2
    srcMode = 0; dstMode = 0; xferSize = 2;
    gatherCount = 3; gatherInterval = 8'h10; gatherDown = 0;
    scatterCount = 2; scatterInterval = 8'h20; scatterDown = 1;
    loadAll(16'h0100, 16'h0800);
    srcAdvance = 1; dstAdvance = 1;
    for (int i = 0; i < 7; i++) doCycle("R5 gather", "R6 scatter");
    // count of one: every beat is a boundary
    gatherCount = 1; scatterCount = 1;
    loadAll(16'h0100, 16'h0800);
    for (int i = 0; i < 3; i++) doCycle("R5 every beat", "R6 every beat");

    // R7: zero count disables jumps
    gatherCount = 0; scatterCount = 0; gatherInterval = 8'hFF; scatterInterval = 8'hFF;
    loadAll(16'h0200, 16'h0300);
    for (int i = 0; i < 6; i++) doCycle("R7 src off", "R7 dst off");

    // R8: only source advances; destination and its count untouched
    scatterCount = 2; scatterDown = 0; scatterInterval = 8'h40;
    loadAll(16'h0000, 16'h0500);
    srcAdvance = 1; dstAdvance = 0;
    for (int i = 0; i < 5; i++) doCycle("R8 src run", "R8 dst still");
    srcAdvance = 0; dstAdvance = 1;
    for (int i = 0; i < 2; i++) doCycle("R8 src still", "R8 dst count intact");

    // R9: wrap upward and downward
    gatherCount = 0; scatterCount = 0; srcMode = 0; dstMode = 1; xferSize = 2;
    loadAll(16'hFFFE, 16'h0001);
    srcAdvance = 1; dstAdvance = 1;
    doCycle("R9 src wrap up", "R9 dst wrap down");
    gatherCount = 1; gatherInterval = 8'hF0;
    doCycle("R9 src jump wrap", "R9 dst wrap");

    // random segments
    for (int seg = 0; seg < 200; seg++) begin
      xferSize = 2'($urandom_range(0, 3));
      srcMode = 2'($urandom_range(0, 3)); dstMode = 2'($urandom_range(0, 3));
      gatherCount = CW'($urandom_range(0, 5)); scatterCount = CW'($urandom_range(0, 5));
      gatherInterval = IW'($urandom); scatterInterval = IW'($urandom);
      gatherDown = 1'($urandom); scatterDown = 1'($urandom);
      srcInit = AW'($urandom); dstInit = AW'($urandom);
      srcAdvance = 1'($urandom); dstAdvance = 1'($urandom);
      start = 1;
      doCycle("R1 rand load", "R1 rand load");
      start = 0;
      for (int k = 0; k < 12; k++) begin
        srcAdvance = ($urandom_range(0, 3) != 0);
        dstAdvance = ($urandom_range(0, 3) != 0);
        doCycle("R5 rand src", "R6 rand dst");
      end
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule